// File: doc/BRIEF.md
# Vector Collector Fetch Engine

This block walks a vector in memory ahead of the compute side. Software gives it a base address, an element size, an element count, a key offset and a direction flag, then pulses a start pin. For each iteration the engine forms the element key by accumulation. It allocates a slot in a small local table and holds that iteration locked. For a load stream it asks the cache for the line that holds the element. Once the line has arrived, it offers the iteration to the compute side. The lock is released when the compute side reports that the iteration's dirty data has been written back.

Keys that land in the same line as the previous request are merged, so each distinct line is requested only once. The engine never runs more than `WIN` iterations ahead of the oldest locked iteration. A store stream writes whole lines, so it allocates slots without reading anything.

The line request and the iteration hand-off both use valid/ready. A source that raises valid holds the valid signal and its payload steady until ready is seen high at a clock edge. Responses from the cache carry no ready: one `rsp_valid` pulse means the oldest outstanding line has been filled, and responses return in request order. The writeback report `wb_valid` is a single-cycle pulse with no ready.

Top module: `vc_fetch_engine`

## Requirements
- R1: Iteration i is offered with `iter_idx` = i and `iter_key` = base + offset + i × element size. Iterations are offered in increasing order starting at 0. The key is computed with additions only, and elements are assumed never to cross a line boundary.
- R2: A load stream requests the line address, which is the key with its low `LB` bits cleared. A new request is made only when an iteration's line differs from the line last requested, so runs of keys in one line produce a single request.
- R3: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_addr` does not change.
- R4: A load iteration is not offered until the response for its line has been received. Each `rsp_valid` pulse completes one request, in order.
- R5: A store stream (`cfg_store` = 1 at start) issues no line requests, and its iterations are offered without waiting for any response.
- R6: At most `WIN` iterations are locked at once, meaning generated but not yet unlocked. Key generation and requests stall while the window is full.
- R7: A `wb_valid` pulse unlocks the oldest iteration that has been handed to compute. It is ignored when no handed-out iteration is still locked.
- R8: One cycle after the last iteration is unlocked, `done` goes high and `busy` low. With a count of 0, `done` rises in the second cycle after start. `done` stays high until the next accepted start.
- R9: A `start` pulse while `busy` is high is ignored, and the running configuration is unaffected.
- R10: After reset, `busy`, `done`, `req_valid` and `iter_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk with the current configuration (ignored when busy) |
| cfg_base | input | AW | Vector base address |
| cfg_offset | input | AW | Key offset added to every element address |
| cfg_elem_size | input | SW | Element size in bytes (stride) |
| cfg_count | input | CW | Number of iterations |
| cfg_store | input | 1 | 1 = store stream, 0 = load stream |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Last walk completed |
| req_valid | output | 1 | Line request valid |
| req_ready | input | 1 | Cache accepts the line request |
| req_addr | output | AW | Line-aligned request address |
| rsp_valid | input | 1 | Oldest outstanding line has been filled |
| iter_valid | output | 1 | An iteration is ready for compute |
| iter_ready | input | 1 | Compute takes the iteration |
| iter_idx | output | CW | Index of the offered iteration |
| iter_key | output | AW | Element key of the offered iteration |
| wb_valid | input | 1 | Writeback of the oldest handed-out iteration is complete |

## Verification
On every cycle the checker confirms that requests hold steady under back-pressure and stay line-aligned. It also confirms that the number of locked iterations never exceeds the window, that a store stream never raises a request, and that iteration indices advance by one per hand-off. It further checks that a start or writeback pulse arriving at the wrong time leaves the internal state unchanged. Whether the keys are correct, whether same-line keys are merged, and whether loads wait for their fill can be shown only by the bench's scenarios, since each depends on a whole configured walk and on the responses returned. The same holds for the exact request count when the window is full and for the `done` timing of an empty walk.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic {
    DIR_LOAD  = 1'b0,
    DIR_STORE = 1'b1
  } dir_e;
endpackage

// File: rtl/vc_keygen.sv
// Accumulating key generator with last-line memory for request merging.
module vc_keygen #(
  parameter int AW = 32,
  parameter int SW = 8,
  parameter int LB = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_key,
  input  logic          advance,
  input  logic [SW-1:0] stride,
  input  logic          take_line,
  output logic [AW-1:0] key,
  output logic [AW-1:0] line_addr,
  output logic          new_line
);
  logic [AW-1:0]    key_q;
  logic [AW-LB-1:0] last_q;
  logic             last_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q  <= '0;
      last_q <= '0;
      last_v <= 1'b0;
    end else if (load) begin
      key_q  <= load_key;
      last_v <= 1'b0;
    end else begin
      if (advance) key_q <= key_q + AW'(stride);
      if (take_line) begin
        last_q <= key_q[AW-1:LB];
        last_v <= 1'b1;
      end
    end
  end

  assign key       = key_q;
  assign line_addr = {key_q[AW-1:LB], LB'(0)};
  assign new_line  = !last_v || (key_q[AW-1:LB] != last_q);
endmodule

// File: rtl/vc_slot_table.sv
// Per-slot storage of element key and the fill sequence it waits for.
module vc_slot_table #(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int WIN = 4,
  localparam int WL = $clog2(WIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [WL-1:0] wr_ptr,
  input  logic [AW-1:0] wr_key,
  input  logic [CW-1:0] wr_tag,
  input  logic [WL-1:0] rd_ptr,
  output logic [AW-1:0] rd_key,
  output logic [CW-1:0] rd_tag
);
  logic [AW-1:0] key_m [WIN];
  logic [CW-1:0] tag_m [WIN];

  for (genvar g = 0; g < WIN; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        key_m[g] <= '0;
        tag_m[g] <= '0;
      end else if (wr_en && wr_ptr == WL'(g)) begin
        key_m[g] <= wr_key;
        tag_m[g] <= wr_tag;
      end
    end
  end

  assign rd_key = key_m[rd_ptr];
  assign rd_tag = tag_m[rd_ptr];
endmodule

// File: rtl/vc_fetch_engine.sv
module vc_fetch_engine #(
  parameter int AW  = 32,
  parameter int SW  = 8,
  parameter int CW  = 16,
  parameter int WIN = 4,
  parameter int LB  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_offset,
  input  logic [SW-1:0] cfg_elem_size,
  input  logic [CW-1:0] cfg_count,
  input  logic          cfg_store,
  output logic          busy,
  output logic          done,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  input  logic          rsp_valid,
  output logic          iter_valid,
  input  logic          iter_ready,
  output logic [CW-1:0] iter_idx,
  output logic [AW-1:0] iter_key,
  input  logic          wb_valid
);
  import vc_pkg::*;
  localparam int WL = $clog2(WIN);

  logic          busy_q, done_q, req_v_q;
  dir_e          store_q;
  logic [SW-1:0] size_q;
  logic [CW-1:0] cnt_q, gen_q, hand_q, free_q, seq_q, rsp_q;
  logic [AW-1:0] req_a_q;

  logic [AW-1:0] key, line_addr, rd_key;
  logic [CW-1:0] rd_tag, lock_cnt, tag_new;
  logic new_line, need_req, req_free, room;
  logic launch, gen_fire, iter_fire, unlock, finish;

  assign launch   = start && !busy_q;
  assign lock_cnt = gen_q - free_q;
  assign room     = lock_cnt < CW'(WIN);
  assign need_req = (store_q == DIR_LOAD) && new_line;
  assign req_free = !req_v_q || req_ready;
  assign gen_fire = busy_q && (gen_q != cnt_q) && room && (!need_req || req_free);
  assign tag_new  = need_req ? seq_q + CW'(1) : seq_q;

  assign iter_valid = busy_q && (hand_q != gen_q) && (rsp_q >= rd_tag);
  assign iter_fire  = iter_valid && iter_ready;
  assign unlock     = busy_q && wb_valid && (free_q != hand_q);
  assign finish     = busy_q && (free_q == cnt_q);

  vc_keygen #(.AW(AW), .SW(SW), .LB(LB)) i_keygen (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (launch),
    .load_key  (cfg_base + cfg_offset),
    .advance   (gen_fire),
    .stride    (size_q),
    .take_line (gen_fire && need_req),
    .key       (key),
    .line_addr (line_addr),
    .new_line  (new_line)
  );

  vc_slot_table #(.AW(AW), .CW(CW), .WIN(WIN)) i_slots (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (gen_fire),
    .wr_ptr (gen_q[WL-1:0]),
    .wr_key (key),
    .wr_tag (tag_new),
    .rd_ptr (hand_q[WL-1:0]),
    .rd_key (rd_key),
    .rd_tag (rd_tag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      req_v_q <= 1'b0;
      req_a_q <= '0;
      store_q <= DIR_LOAD;
      size_q  <= '0;
      cnt_q   <= '0;
      gen_q   <= '0;
      hand_q  <= '0;
      free_q  <= '0;
      seq_q   <= '0;
      rsp_q   <= '0;
    end else if (launch) begin
      busy_q  <= 1'b1;
      done_q  <= 1'b0;
      req_v_q <= 1'b0;
      store_q <= dir_e'(cfg_store);
      size_q  <= cfg_elem_size;
      cnt_q   <= cfg_count;
      gen_q   <= '0;
      hand_q  <= '0;
      free_q  <= '0;
      seq_q   <= '0;
      rsp_q   <= '0;
    end else if (busy_q) begin
      if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
      if (gen_fire) gen_q <= gen_q + CW'(1);
      if (gen_fire && need_req) begin
        req_v_q <= 1'b1;
        req_a_q <= line_addr;
        seq_q   <= seq_q + CW'(1);
      end else if (req_v_q && req_ready) begin
        req_v_q <= 1'b0;
      end
      if (iter_fire) hand_q <= hand_q + CW'(1);
      if (unlock)    free_q <= free_q + CW'(1);
      if (rsp_valid) rsp_q  <= rsp_q + CW'(1);
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign req_valid = req_v_q;
  assign req_addr  = req_a_q;
  assign iter_idx  = hand_q;
  assign iter_key  = rd_key;
endmodule

// File: rtl/vc_fetch_checker.sv
module vc_fetch_checker #(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int WIN = 4,
  parameter int LB  = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          iter_valid,
  input logic          iter_ready,
  input logic [CW-1:0] iter_idx,
  input logic          wb_valid,
  input logic          store_q,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] gen_q,
  input logic [CW-1:0] hand_q,
  input logic [CW-1:0] free_q
);
  p_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    iter_valid && iter_ready |=> iter_idx == $past(iter_idx) + CW'(1));

  p_line_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[LB-1:0] == '0);

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));

  p_store_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && store_q |-> !req_valid);

  p_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_q - free_q) <= CW'(WIN));

  p_wb_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wb_valid && free_q == hand_q |=> free_q == $past(free_q));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !iter_valid && !req_valid);

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> cnt_q == $past(cnt_q) && store_q == $past(store_q));
endmodule

bind vc_fetch_engine vc_fetch_checker #(.AW(AW), .CW(CW), .WIN(WIN), .LB(LB)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .iter_valid (iter_valid),
  .iter_ready (iter_ready),
  .iter_idx   (iter_idx),
  .wb_valid   (wb_valid),
  .store_q    (store_q),
  .cnt_q      (cnt_q),
  .gen_q      (gen_q),
  .hand_q     (hand_q),
  .free_q     (free_q)
);

// File: tb/test_vc_fetch_engine.sv
module test_vc_fetch_engine;
  localparam int AW = 32, SW = 8, CW = 16, WIN = 4, LB = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, cfg_store, req_ready, rsp_valid, iter_ready, wb_valid;
  logic [AW-1:0] cfg_base, cfg_offset, req_addr, iter_key;
  logic [SW-1:0] cfg_elem_size;
  logic [CW-1:0] cfg_count, iter_idx;
  logic busy, done, req_valid, iter_valid;

  vc_fetch_engine #(.AW(AW), .SW(SW), .CW(CW), .WIN(WIN), .LB(LB)) i_vc_fetch_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(cfg_base), .cfg_offset(cfg_offset),
    .cfg_elem_size(cfg_elem_size), .cfg_count(cfg_count), .cfg_store(cfg_store),
    .busy(busy), .done(done), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .iter_valid(iter_valid),
    .iter_ready(iter_ready), .iter_idx(iter_idx), .iter_key(iter_key), .wb_valid(wb_valid)
  );

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] off;
    logic [7:0]  size;
    logic [15:0] count;
    logic        store;
    logic [7:0]  nreq;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{32'h1000, 32'h0,  8'd4,   16'd20, 1'b0, 8'd2},
    '{32'h2000, 32'h10, 8'd16,  16'd10, 1'b0, 8'd3},
    '{32'h3000, 32'h0,  8'd64,  16'd5,  1'b0, 8'd5},
    '{32'h4000, 32'h0,  8'd8,   16'd12, 1'b1, 8'd0},
    '{32'h5000, 32'h40, 8'd128, 16'd3,  1'b0, 8'd3}
  };

  int checks = 0, errors = 0;
  logic [31:0] exp_line [64];
  int exp_nreq, nreq, nit, owed, wbq;
  logic [31:0] e_base, e_off;
  int e_size, e_n;
  bit en_rsp, force_wb;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic prepare(input logic [31:0] b, input logic [31:0] o, input int s, input int n, input bit st);
    logic [31:0] prev;
    e_base = b; e_off = o; e_size = s; e_n = n;
    exp_nreq = 0; nreq = 0; nit = 0; owed = 0; wbq = 0;
    prev = '1;
    for (int i = 0; i < n; i++) begin
      logic [31:0] k;
      k = b + o + 32'(i * s);
      if (!st && (i == 0 || (k & ~32'h3F) != prev)) begin
        exp_line[exp_nreq] = k & ~32'h3F;
        exp_nreq++;
        prev = k & ~32'h3F;
      end
    end
  endtask

  // One cycle, entered and left 1 ns after a rising edge.
  task automatic tick();
    rsp_valid = en_rsp && owed > 0;
    if (rsp_valid) owed--;
    wb_valid = force_wb || wbq > 0;
    if (!force_wb && wbq > 0) wbq--;
    #0.5;
    if (req_valid && req_ready) begin
      if (nreq < exp_nreq) chk(req_addr == exp_line[nreq], "R2 line address", req_addr, exp_line[nreq]);
      else chk(1'b0, "R2/R5 unexpected request", req_addr, 0);
      nreq++; owed++;
    end
    if (iter_valid && iter_ready) begin
      chk(iter_idx == CW'(nit), "R1 iteration index", 32'(iter_idx), nit);
      chk(iter_key == e_base + e_off + 32'(nit * e_size), "R1 key", iter_key, e_base + e_off + 32'(nit * e_size));
      nit++; wbq++;
    end
    @(posedge clk); #1;
  endtask

  task automatic launch(input logic [31:0] b, input logic [31:0] o, input int s, input int n, input bit st);
    cfg_base = b; cfg_offset = o; cfg_elem_size = SW'(s); cfg_count = CW'(n); cfg_store = st;
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic run_to_done(input string tag);
    int c = 0;
    while (!done && c < 2000) begin tick(); c++; end
    chk(done && !busy, {tag, " R8 done"}, 32'(done), 1);
    chk(nreq == exp_nreq, {tag, " R2 request count"}, nreq, exp_nreq);
    chk(nit == e_n, {tag, " R1 iteration count"}, nit, e_n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; start = 0; cfg_base = 0; cfg_offset = 0; cfg_elem_size = 0; cfg_count = 0;
    cfg_store = 0; req_ready = 1; rsp_valid = 0; iter_ready = 1; wb_valid = 0;
    en_rsp = 1; force_wb = 0;
    repeat (3) @(posedge clk); #1;
    chk(!busy && !done && !req_valid && !iter_valid, "R10 reset state",
        {28'h0, busy, done, req_valid, iter_valid}, 0);
    rst_n = 1;
    @(posedge clk); #1;

    // Table-driven walks: R1, R2, R4, R5, R7, R8
    for (int v = 0; v < NV; v++) begin
      prepare(VECS[v].base, VECS[v].off, VECS[v].size, VECS[v].count, VECS[v].store);
      chk(exp_nreq == VECS[v].nreq, "R2 table line count", exp_nreq, VECS[v].nreq);
      launch(VECS[v].base, VECS[v].off, VECS[v].size, VECS[v].count, VECS[v].store);
      run_to_done($sformatf("vec%0d", v));
    end

    // R8: empty walk
    prepare(32'h6000, 0, 4, 0, 0);
    launch(32'h6000, 0, 4, 0, 0);
    chk(busy && !done, "R8 busy after start", {31'h0, done}, 0);
    tick();
    chk(done && !busy, "R8 empty walk done", {31'h0, done}, 1);

    // R6, R7, R9: full window with compute stalled
    prepare(32'h8000, 0, 64, 8, 0);
    iter_ready = 0;
    launch(32'h8000, 0, 64, 8, 0);
    repeat (12) tick();
    chk(nreq == WIN, "R6 window limits requests", nreq, WIN);
    chk(iter_valid && iter_idx == 0, "R4 first iteration ready after fill", 32'(iter_valid), 1);
    force_wb = 1; tick(); force_wb = 0;
    cfg_base = 32'hF000; cfg_count = 2; cfg_store = 1;
    start = 1; tick(); start = 0;
    repeat (8) tick();
    chk(nreq == WIN, "R7 spurious writeback ignored", nreq, WIN);
    chk(busy && iter_key == 32'h8000, "R9 start ignored while busy", iter_key, 32'h8000);
    iter_ready = 1;
    run_to_done("window");

    // R4: fill withheld
    prepare(32'hA000, 0, 4, 2, 0);
    en_rsp = 0;
    launch(32'hA000, 0, 4, 2, 0);
    repeat (6) tick();
    chk(nit == 0 && !iter_valid, "R4 no iteration before fill", nit, 0);
    chk(nreq == 1, "R2 merged request while waiting", nreq, 1);
    en_rsp = 1;
    run_to_done("fillwait");

    // R3: request back-pressure
    prepare(32'hC000, 0, 64, 3, 0);
    req_ready = 0;
    launch(32'hC000, 0, 64, 3, 0);
    tick();
    for (int i = 0; i < 4; i++) begin
      tick();
      chk(req_valid && req_addr == 32'hC000, "R3 request held", req_addr, 32'hC000);
    end
    req_ready = 1;
    run_to_done("backpressure");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule